// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

An eight-bit synchronous counter whose register updates only on the rising clock edge. A two-bit operation select picks one of four operations: zero the count, load it from a parallel data input, count up by one, or count down by one. All of these take effect at the next clock edge. Counting needs two active-low permits, a parallel permit and a trickle permit, to be low together. Zeroing and loading do not depend on either permit.

An active-low carry output goes low when the count sits at the terminal value for the selected direction. That value is all ones when counting up and all zeros when counting down, and the carry goes low only while the trickle permit is low. The carry is combinational, so a wider counter is built by chaining stages. Each stage's carry feeds the trickle permit of the next stage up, and all stages share the clock, the operation select and the parallel permit. No other glue logic is needed.

A synchronous active-high reset zeroes the count for simulation start-up.

Top module: `updn_ctr`

## Requirements
- R1: When `rst` is high at a rising edge, `cnt` is 0 after that edge, whatever the other inputs are.
- R2: With `op_sel` = 2'b00 (zero), `cnt` becomes 0 at the next rising edge, even when both permits are high.
- R3: With `op_sel` = 2'b10 (load), `cnt` takes the value of `din` at the next rising edge, even when both permits are high.
- R4: With `op_sel` = 2'b11 (up) and both permits low, `cnt` increases by one at each rising edge, and 255 wraps to 0.
- R5: With `op_sel` = 2'b01 (down) and both permits low, `cnt` decreases by one at each rising edge, and 0 wraps to 255.
- R6: In either counting operation, `cnt` holds its value across an edge if `par_en_n` or `trk_en_n` is high.
- R7: `carry_n` is low exactly when `trk_en_n` is low and either `op_sel` = 2'b11 with `cnt` = 255, or `op_sel` = 2'b01 with `cnt` = 0. It is high in every other case, including the zero and load operations. It follows its inputs in the same cycle, with no clock edge needed.
- R8: A change on `op_sel` between clock edges leaves `cnt` unchanged until the next rising edge.
- R9: Two stages, with the lower stage's `carry_n` driving the upper stage's `trk_en_n` and all other controls shared, count as one 16-bit counter in both directions, including across the byte boundary and on 16-bit wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | Operation: 00 zero, 01 down, 10 load, 11 up |
| par_en_n | input | 1 | Active-low parallel count permit |
| trk_en_n | input | 1 | Active-low trickle count permit, also gates the carry |
| din | input | 8 | Parallel load value |
| cnt | output | 8 | Current count |
| carry_n | output | 1 | Active-low terminal-count carry |

## Verification
The count sits behind one register, so every change to `cnt` caused by a stimulus is due right after the first rising edge that follows it. The bench drives inputs on the falling edge and reads `cnt` 1 ns after the next rising edge. `carry_n` has no register in its path, so the bench reads it half a nanosecond after driving the inputs, within the same cycle and before the edge. For R8, the bench changes the operation select several times inside one low clock phase and reads `cnt` before the edge arrives.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;

    typedef enum logic [1:0] {
        OP_ZERO = 2'b00,
        OP_DOWN = 2'b01,
        OP_LOAD = 2'b10,
        OP_UP   = 2'b11
    } op_e;

    typedef struct packed {
        logic zero;
        logic load;
        logic go_up;
        logic go_down;
    } ctl_t;

    function automatic ctl_t decode_op(input op_e op);
        ctl_t c;
        c = '0;
        unique case (op)
            OP_ZERO: c.zero    = 1'b1;
            OP_LOAD: c.load    = 1'b1;
            OP_UP:   c.go_up   = 1'b1;
            OP_DOWN: c.go_down = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/updn_ctr_decode.sv
module updn_ctr_decode
    import updn_ctr_pkg::*;
(
    input  logic [1:0] op_sel,
    output ctl_t       ctl
);
    always_comb ctl = decode_op(op_e'(op_sel));
endmodule

// File: rtl/updn_ctr_next.sv
module updn_ctr_next
    import updn_ctr_pkg::*;
#(
    parameter int W = 8
) (
    input  ctl_t         ctl,
    input  logic         par_en_n,
    input  logic         trk_en_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] din,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic permit;
    assign permit = ~par_en_n & ~trk_en_n;

    always_comb begin
        nxt = cur;
        if (ctl.zero)
            nxt = '0;
        else if (ctl.load)
            nxt = din;
        else if (permit && ctl.go_up)
            nxt = cur + ONE;
        else if (permit && ctl.go_down)
            nxt = cur - ONE;
    end
endmodule

// File: rtl/updn_ctr_reg.sv
module updn_ctr_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/updn_ctr_carry.sv
module updn_ctr_carry
    import updn_ctr_pkg::*;
#(
    parameter int W = 8
) (
    input  ctl_t         ctl,
    input  logic         trk_en_n,
    input  logic [W-1:0] cnt,
    output logic         carry_n
);
    logic [W-1:0] bit_hit;

    for (genvar i = 0; i < W; i++) begin : g_hit
        assign bit_hit[i] = ctl.go_up ? cnt[i] : ~cnt[i];
    end

    logic counting;
    assign counting = ctl.go_up | ctl.go_down;
    assign carry_n  = ~(~trk_en_n & counting & (&bit_hit));
endmodule

// File: rtl/updn_ctr.sv
module updn_ctr
    import updn_ctr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   op_sel,
    input  logic         par_en_n,
    input  logic         trk_en_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cnt,
    output logic         carry_n
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    ctl_t         ctl;
    logic [W-1:0] nxt;

    updn_ctr_decode u_decode (.op_sel(op_sel), .ctl(ctl));

    updn_ctr_next #(.W(W)) u_next (
        .ctl(ctl), .par_en_n(par_en_n), .trk_en_n(trk_en_n),
        .cur(cnt), .din(din), .nxt(nxt)
    );

    updn_ctr_reg #(.W(W)) u_reg (
        .clk(clk), .rst(rst), .nxt(nxt), .q(cnt)
    );

    updn_ctr_carry #(.W(W)) u_carry (
        .ctl(ctl), .trk_en_n(trk_en_n), .cnt(cnt), .carry_n(carry_n)
    );

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (cnt == '0));

    a_r2_zero_op: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b00) |=> (cnt == '0));

    a_r3_load_op: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b10) |=> (cnt == $past(din)));

    a_r4_count_up: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b11 && !par_en_n && !trk_en_n) |=> (cnt == $past(cnt) + ONE));

    a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b01 && !par_en_n && !trk_en_n) |=> (cnt == $past(cnt) - ONE));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (op_sel[0] && (par_en_n || trk_en_n)) |=> $stable(cnt));

    a_r7_carry_terminal: assert property (@(posedge clk) disable iff (rst)
        !carry_n |-> (!trk_en_n && op_sel[0] && (cnt == '0 || cnt == '1)));
endmodule

// File: tb/updn_ctr_bench.sv
`timescale 1ns/1ps
module updn_ctr_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] op_sel = 2'b00;
    logic       par_en_n = 1'b1;
    logic       trk_en_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] din_hi = 8'h00;
    logic [7:0] cnt_lo, cnt_hi;
    logic       carry_lo, carry_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    updn_ctr u_updn_ctr (
        .clk(clk), .rst(rst), .op_sel(op_sel), .par_en_n(par_en_n),
        .trk_en_n(trk_en_n), .din(din), .cnt(cnt_lo), .carry_n(carry_lo)
    );

    updn_ctr u_updn_ctr_hi (
        .clk(clk), .rst(rst), .op_sel(op_sel), .par_en_n(par_en_n),
        .trk_en_n(carry_lo), .din(din_hi), .cnt(cnt_hi), .carry_n(carry_hi)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // {op_sel, par_en_n, trk_en_n, din, carry before edge, cnt after edge}
    localparam int NV = 15;
    localparam logic [20:0] VEC [NV] = '{
        {2'b10, 1'b1, 1'b1, 8'hFE, 1'b1, 8'hFE},  // R3 load with permits high
        {2'b11, 1'b0, 1'b0, 8'h00, 1'b1, 8'hFF},  // R4
        {2'b11, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},  // R4 wrap, R7 up terminal
        {2'b11, 1'b1, 1'b0, 8'h00, 1'b1, 8'h00},  // R6 parallel permit high
        {2'b11, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00},  // R6 trickle permit high
        {2'b01, 1'b0, 1'b0, 8'h00, 1'b0, 8'hFF},  // R5 wrap, R7 down terminal
        {2'b01, 1'b0, 1'b0, 8'h00, 1'b1, 8'hFE},  // R5
        {2'b01, 1'b1, 1'b0, 8'h00, 1'b1, 8'hFE},  // R6
        {2'b10, 1'b1, 1'b1, 8'h5A, 1'b1, 8'h5A},  // R3
        {2'b11, 1'b0, 1'b0, 8'h00, 1'b1, 8'h5B},  // R4
        {2'b00, 1'b1, 1'b1, 8'hAA, 1'b1, 8'h00},  // R2 with permits high
        {2'b01, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00},  // R7 trickle high masks carry
        {2'b10, 1'b0, 1'b0, 8'hFF, 1'b1, 8'hFF},  // R7 load op keeps carry high
        {2'b11, 1'b1, 1'b0, 8'h00, 1'b0, 8'hFF},  // R7 parallel permit does not gate carry
        {2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00}   // R2, R7 zero op keeps carry high
    };

    task automatic step16(input logic [1:0] op, input logic [15:0] ld, inout logic [15:0] model);
        @(negedge clk);
        op_sel = op; par_en_n = 1'b0; trk_en_n = 1'b0;
        din = ld[7:0]; din_hi = ld[15:8];
        @(posedge clk);
        #1;
        case (op)
            2'b00: model = 16'h0000;
            2'b10: model = ld;
            2'b11: model = model + 16'h0001;
            default: model = model - 16'h0001;
        endcase
        check("R9 cascade count", {cnt_hi, cnt_lo}, model);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        logic [15:0] model;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset count", {8'h00, cnt_lo}, 16'h0000);
        check("R7 reset carry", {15'h0, carry_lo}, 16'h0001);
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {op_sel, par_en_n, trk_en_n, din} = VEC[i][20:9];
            #0.5;
            check($sformatf("R7 vector %0d carry", i), {15'h0, carry_lo}, {15'h0, VEC[i][8]});
            @(posedge clk);
            #1;
            check($sformatf("R2-6 vector %0d count", i), {8'h00, cnt_lo}, {8'h00, VEC[i][7:0]});
        end

        // R8: op changes inside one cycle have no effect before the edge
        @(negedge clk); op_sel = 2'b10; din = 8'h33; par_en_n = 1'b0; trk_en_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); op_sel = 2'b11;
        #0.4; op_sel = 2'b00;
        #0.4; op_sel = 2'b01;
        #0.4;
        check("R8 cnt before edge", {8'h00, cnt_lo}, 16'h0033);
        @(posedge clk); #1;
        check("R8 cnt after edge uses final op", {8'h00, cnt_lo}, 16'h0032);

        // R1: reset overrides counting
        @(negedge clk); op_sel = 2'b11; rst = 1'b1;
        @(posedge clk); #1;
        check("R1 reset during count", {8'h00, cnt_lo}, 16'h0000);
        @(negedge clk); rst = 1'b0;

        // R9: 16-bit cascade across the byte boundary, both ways
        model = 16'h0000;
        step16(2'b10, 16'h00FD, model);
        for (int k = 0; k < 5; k++) step16(2'b11, 16'h0000, model);
        step16(2'b10, 16'h0102, model);
        for (int k = 0; k < 5; k++) step16(2'b01, 16'h0000, model);
        step16(2'b10, 16'hFFFE, model);
        step16(2'b11, 16'h0000, model);
        #0.5;
        check("R9 top carry at all ones", {15'h0, carry_hi}, 16'h0000);
        step16(2'b11, 16'h0000, model);
        step16(2'b01, 16'h0000, model);
        step16(2'b00, 16'h1234, model);

        done = 1'b1;
        finish_run();
    end
endmodule